// File: doc/BRIEF.md
# Programmable memory pattern sequencer

This block drives a memory's control lines from a small writable table of 32-bit pattern words. Three independent machines share the table and one execution engine. Each pattern begins at a start address. The engine then steps through consecutive words, one per clock, and stops once it has executed a word flagged as final. Each executed word appears on the outputs. The chip selects follow the word's select bit and the set of banks that the running request covers.

Three sources can request a pattern:
- A shared refresh timer divides the clock by a fixed prescaler and then by a programmable period. Each refresh runs the single refresh pattern at the top of the table. The banks of every machine whose refresh enable is set are selected at the same time. No refresh happens at all unless machine 0 has its refresh enable set.
- Software can launch a pattern on one machine. It programs that machine's opcode to the run code and then writes into the machine's region. In these patterns the acknowledge bit is masked.
- A bus-monitor timeout runs a dedicated recovery pattern on the bank that timed out.

Requests are latched and served in a fixed priority order. A request never interrupts a pattern that is already running.

Top module: `patseq_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pat_word`, `chip_sel` and `xfer_ack` are all zero.
- R2: With `refresh_period` = P > 0 and `cfg_rfen[0]` set, refresh patterns start exactly every 32·P clocks. With P = 0, no refresh is ever requested.
- R3: When `cfg_rfen[0]` is clear, timer expiries are dropped and no refresh pattern runs, whatever `cfg_rfen[2:1]` hold.
- R4: A refresh executes the words from address 0x30 onward. Its chip-select mask has bit 0 set, and bit i (i = 1, 2) set when `cfg_rfen[i]` is set, so several selects can be high together.
- R5: Machine m launches a software run only when `region_wr[m]` is high while `cfg_op[2m+1:2m]` = 2'b11. With any other opcode the write is ignored and `pat_word` stays zero.
- R6: A software run that is accepted on the edge where `region_wr[m]` is sampled high puts the word at `cfg_start[6m+5:6m]` on `pat_word` two edges later. It then presents one word per clock at consecutive addresses, through the first word whose bit 0 (final flag) is set. On the next edge the outputs return to zero.
- R7: `xfer_ack` is high for an executed word whose bit 1 is set, except during a software run, where it stays low.
- R8: A `bmon_timeout` pulse runs the words from address 0x3C onward. The chip select is bit `bmon_bank` when `bmon_bank` < 3, and none otherwise.
- R9: When several requests are pending, the order of service is: timeout first, then refresh, then software runs from the lowest-numbered machine upward.
- R10: A request that arrives while a pattern is running waits until that pattern's final word has been presented. The next pattern's first word follows after exactly one idle cycle.
- R11: A write through `ram_we`/`ram_waddr`/`ram_wdata` replaces the table word that later runs fetch. `chip_sel` shows the request's mask only for words whose bit 4 is set, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rfen | input | 3 | Per-machine refresh enable |
| cfg_op | input | 6 | Per-machine 2-bit opcode; 2'b11 selects run |
| cfg_start | input | 18 | Per-machine 6-bit run start address |
| refresh_period | input | 8 | Refresh divider after the prescaler; 0 disables refresh |
| region_wr | input | 3 | Write strobe hitting each machine's region |
| bmon_timeout | input | 1 | Bus-monitor timeout pulse |
| bmon_bank | input | 2 | Bank that timed out |
| ram_we | input | 1 | Pattern table write enable |
| ram_waddr | input | 6 | Pattern table write address |
| ram_wdata | input | 32 | Pattern table write data |
| chip_sel | output | 3 | Active-high bank selects |
| pat_word | output | 32 | Word currently executed (zero when idle) |
| xfer_ack | output | 1 | Transfer acknowledge |

## Verification
The hardest situation to reach is all three request kinds pending at once while the engine is idle, because the refresh timer runs freely and its phase cannot be set from the ports. The stimulus first waits for a refresh pattern to appear on `pat_word`. From that moment it counts clocks to the edge where the next timer expiry is latched. On that same edge it pulses the timeout and two region writes. The order of the following patterns then shows the full priority chain. A second scenario places the same requests in the middle of a running pattern to check that nothing preempts it. A sweep over every machine and start address checks the run timing and how the final flag ends each pattern.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  typedef enum logic [1:0] {K_NONE, K_EXC, K_REF, K_RUN} kind_e;
  localparam int LAST_BIT = 0;
  localparam int ACK_BIT  = 1;
  localparam int CS_BIT   = 4;
  localparam logic [1:0] OP_RUN = 2'b11;
endpackage

// File: rtl/patseq_ram.sv
module patseq_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/patseq_timer.sv
module patseq_timer #(
  parameter int PRESCALE = 32,
  parameter int PER_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(PRESCALE - 1);

  logic [PW-1:0]    pre_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             pre_wrap;

  assign pre_wrap = (pre_cnt == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      per_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick    <= 1'b0;
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (period == '0) begin
        per_cnt <= '0;
      end else if (pre_wrap) begin
        if (per_cnt >= period - 1'b1) begin
          per_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          per_cnt <= per_cnt + 1'b1;
        end
      end
    end
  end

  assert_tick_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(pre_wrap));
  assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(period) != '0));
endmodule

// File: rtl/patseq_arb.sv
module patseq_arb import patseq_pkg::*; #(
  parameter int NM = 3,
  parameter int AW = 6,
  parameter logic [AW-1:0] REF_BASE = 6'h30,
  parameter logic [AW-1:0] EXC_BASE = 6'h3C
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NM-1:0]          rfen,
  input  logic [2*NM-1:0]        op,
  input  logic [AW*NM-1:0]       start_cfg,
  input  logic [NM-1:0]          wr_hit,
  input  logic                   ref_tick,
  input  logic                   bmon_timeout,
  input  logic [$clog2(NM)-1:0]  bmon_bank,
  input  logic                   engine_idle,
  output logic                   grant,
  output kind_e                  g_kind,
  output logic [AW-1:0]          g_addr,
  output logic [NM-1:0]          g_mask
);
  localparam int BW = $clog2(NM);

  logic          exc_pend, ref_pend;
  logic [BW-1:0] exc_bank;
  logic [NM-1:0] run_pend, run_evt, run_clr, exc_mask;
  logic [BW-1:0] run_idx;

  // software run event per machine
  for (genvar i = 0; i < NM; i++) begin : g_run_evt
    assign run_evt[i]  = wr_hit[i] && (op[2*i +: 2] == OP_RUN);
    assign exc_mask[i] = (exc_bank == BW'(i));
  end

  always_comb begin
    run_idx = '0;
    for (int i = NM - 1; i >= 0; i--)
      if (run_pend[i]) run_idx = BW'(i);
  end

  always_comb begin
    grant  = engine_idle && (exc_pend || ref_pend || (run_pend != '0));
    g_kind = K_NONE;
    g_addr = '0;
    g_mask = '0;
    if (exc_pend) begin
      g_kind = K_EXC;
      g_addr = EXC_BASE;
      g_mask = exc_mask;
    end else if (ref_pend) begin
      g_kind = K_REF;
      g_addr = REF_BASE;
      g_mask = rfen | NM'(1);
    end else if (run_pend != '0) begin
      g_kind = K_RUN;
      g_addr = start_cfg[run_idx*AW +: AW];
      g_mask = NM'(1) << run_idx;
    end
  end

  assign run_clr = (grant && g_kind == K_RUN) ? (NM'(1) << run_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pend <= 1'b0;
      exc_bank <= '0;
      ref_pend <= 1'b0;
      run_pend <= '0;
    end else begin
      exc_pend <= (exc_pend && !(grant && g_kind == K_EXC)) || bmon_timeout;
      if (bmon_timeout) exc_bank <= bmon_bank;
      ref_pend <= (ref_pend && !(grant && g_kind == K_REF)) || (ref_tick && rfen[0]);
      run_pend <= (run_pend & ~run_clr) | run_evt;
    end
  end

  assert_exc_first_R9: assert property (@(posedge clk) disable iff (rst)
    (grant && exc_pend) |-> (g_kind == K_EXC));
  assert_ref_needs_a_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_pend) |-> $past(rfen[0]));
  assert_ref_mask_a_R4: assert property (@(posedge clk) disable iff (rst)
    (grant && g_kind == K_REF) |-> g_mask[0]);
  assert_one_run_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(run_clr));
endmodule

// File: rtl/patseq_engine.sv
module patseq_engine import patseq_pkg::*; #(
  parameter int NM = 3,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  kind_e         g_kind,
  input  logic [AW-1:0] g_addr,
  input  logic [NM-1:0] g_mask,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          idle,
  output logic [DW-1:0] pat_word,
  output logic [NM-1:0] chip_sel,
  output logic          xfer_ack
);
  logic          busy;
  logic [AW-1:0] pc;
  kind_e         kind;
  logic [NM-1:0] mask;

  assign idle    = !busy;
  // prefetch: first word on grant, next word while executing
  assign rd_addr = busy ? pc + 1'b1 : g_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pc       <= '0;
      kind     <= K_NONE;
      mask     <= '0;
      pat_word <= '0;
      chip_sel <= '0;
      xfer_ack <= 1'b0;
    end else if (!busy) begin
      pat_word <= '0;
      chip_sel <= '0;
      xfer_ack <= 1'b0;
      if (grant) begin
        busy <= 1'b1;
        pc   <= g_addr;
        kind <= g_kind;
        mask <= g_mask;
      end
    end else begin
      pat_word <= rd_data;
      chip_sel <= rd_data[CS_BIT] ? mask : '0;
      xfer_ack <= rd_data[ACK_BIT] && (kind != K_RUN);
      if (rd_data[LAST_BIT]) busy <= 1'b0;
      else                   pc   <= pc + 1'b1;
    end
  end

  assert_run_no_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && kind == K_RUN) |=> !xfer_ack);
  assert_no_preempt_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !grant);
  assert_last_stops_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_data[LAST_BIT]) |=> !busy);
endmodule

// File: rtl/patseq_top.sv
module patseq_top import patseq_pkg::*; #(
  parameter int NM       = 3,
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int PRESCALE = 32,
  parameter int PER_W    = 8,
  parameter logic [AW-1:0] REF_BASE = 6'h30,
  parameter logic [AW-1:0] EXC_BASE = 6'h3C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NM-1:0]         cfg_rfen,
  input  logic [2*NM-1:0]       cfg_op,
  input  logic [AW*NM-1:0]      cfg_start,
  input  logic [PER_W-1:0]      refresh_period,
  input  logic [NM-1:0]         region_wr,
  input  logic                  bmon_timeout,
  input  logic [$clog2(NM)-1:0] bmon_bank,
  input  logic                  ram_we,
  input  logic [AW-1:0]         ram_waddr,
  input  logic [DW-1:0]         ram_wdata,
  output logic [NM-1:0]         chip_sel,
  output logic [DW-1:0]         pat_word,
  output logic                  xfer_ack
);
  logic          ref_tick, idle, grant;
  kind_e         g_kind;
  logic [AW-1:0] g_addr, rd_addr;
  logic [NM-1:0] g_mask;
  logic [DW-1:0] rd_data;

  patseq_timer #(.PRESCALE(PRESCALE), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period(refresh_period), .tick(ref_tick));

  patseq_arb #(.NM(NM), .AW(AW), .REF_BASE(REF_BASE), .EXC_BASE(EXC_BASE)) u_arb (
    .clk(clk), .rst(rst), .rfen(cfg_rfen), .op(cfg_op), .start_cfg(cfg_start),
    .wr_hit(region_wr), .ref_tick(ref_tick), .bmon_timeout(bmon_timeout),
    .bmon_bank(bmon_bank), .engine_idle(idle), .grant(grant), .g_kind(g_kind),
    .g_addr(g_addr), .g_mask(g_mask));

  patseq_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(rd_data));

  patseq_engine #(.NM(NM), .AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .grant(grant), .g_kind(g_kind), .g_addr(g_addr),
    .g_mask(g_mask), .rd_data(rd_data), .rd_addr(rd_addr), .idle(idle),
    .pat_word(pat_word), .chip_sel(chip_sel), .xfer_ack(xfer_ack));

  assert_ack_has_word_R7: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> pat_word[ACK_BIT]);
  assert_cs_needs_bit_R11: assert property (@(posedge clk) disable iff (rst)
    (chip_sel != '0) |-> pat_word[CS_BIT]);
endmodule

// File: tb/tb_patseq_top.sv
`timescale 1ns/1ps
module tb_patseq_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cfg_rfen;
  logic [5:0]  cfg_op;
  logic [17:0] cfg_start;
  logic [7:0]  refresh_period;
  logic [2:0]  region_wr;
  logic        bmon_timeout;
  logic [1:0]  bmon_bank;
  logic        ram_we;
  logic [5:0]  ram_waddr;
  logic [31:0] ram_wdata;
  logic [2:0]  chip_sel;
  logic [31:0] pat_word;
  logic        xfer_ack;

  int checks = 0;
  int errors = 0;

  logic [31:0] cap_w [64];
  logic [2:0]  cap_cs [64];
  logic        cap_ack [64];
  int          cap_n;
  logic [31:0] exp_w [64];
  logic [2:0]  exp_cs [64];
  logic        exp_ack [64];
  int          exp_n;

  always #2.5 clk = ~clk;

  patseq_top dut (
    .clk(clk), .rst(rst), .cfg_rfen(cfg_rfen), .cfg_op(cfg_op), .cfg_start(cfg_start),
    .refresh_period(refresh_period), .region_wr(region_wr), .bmon_timeout(bmon_timeout),
    .bmon_bank(bmon_bank), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .chip_sel(chip_sel), .pat_word(pat_word), .xfer_ack(xfer_ack));

  // table contents: address tag in bits 13:8, select bit 4, ack bit 1, final flag every 4th word
  function automatic logic [31:0] wexp(input int a);
    return (32'(a) << 8) | 32'h12 | ((a % 4 == 3) ? 32'h1 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input int m, input int s);
    cfg_start[m*6 +: 6] = 6'(s);
    @(negedge clk) region_wr = 3'(1 << m);
    @(negedge clk) region_wr = 3'b0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4 - (s % 4); k++) begin
      chk("R6 word", pat_word, wexp(s + k));
      chk("R6 cs", 32'(chip_sel), 32'(1 << m));
      chk("R7 run ack", 32'(xfer_ack), 32'd0);
      @(negedge clk);
    end
    chk("R6 end", pat_word, 32'd0);
    chk("R6 end cs", 32'(chip_sel), 32'd0);
  endtask

  task automatic capture(input int n);
    cap_n = 0;
    repeat (n) begin
      @(negedge clk);
      if (pat_word != 0 && cap_n < 64) begin
        cap_w[cap_n] = pat_word; cap_cs[cap_n] = chip_sel; cap_ack[cap_n] = xfer_ack;
        cap_n++;
      end
    end
  endtask

  task automatic add_pat(input int s, input logic [2:0] cs, input logic ack);
    for (int k = 0; k < 4 - (s % 4); k++) begin
      exp_w[exp_n] = wexp(s + k); exp_cs[exp_n] = cs; exp_ack[exp_n] = ack;
      exp_n++;
    end
  endtask

  task automatic compare_cap(input string req);
    chk(req, 32'(cap_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(req, cap_w[i], exp_w[i]);
      chk(req, 32'(cap_cs[i]), 32'(exp_cs[i]));
      chk(req, 32'(cap_ack[i]), 32'(exp_ack[i]));
    end
  endtask

  task automatic wait_ref_start(output int n);
    logic [31:0] prev;
    prev = pat_word;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (pat_word == wexp(48) && prev != wexp(48)) break;
      prev = pat_word;
      if (n > 400) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int zeros;
    rst = 1'b1; cfg_rfen = 3'b0; cfg_op = 6'b111111; cfg_start = '0;
    refresh_period = 8'd0; region_wr = 3'b0; bmon_timeout = 1'b0; bmon_bank = 2'd0;
    ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      ram_we = 1'b1; ram_waddr = 6'(a); ram_wdata = wexp(a);
    end
    @(negedge clk) ram_we = 1'b0;
    // R1 reset state
    chk("R1 word", pat_word, 32'd0);
    chk("R1 cs", 32'(chip_sel), 32'd0);
    chk("R1 ack", 32'(xfer_ack), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after", pat_word | 32'(chip_sel) | 32'(xfer_ack), 32'd0);

    // R5 R6 R7: every machine, every start address below the reserved area
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 48; s++)
        run_one(m, s);

    // R5: other opcodes ignore the region write
    for (int m = 0; m < 3; m++)
      for (int op = 0; op < 3; op++) begin
        cfg_op[2*m +: 2] = 2'(op);
        @(negedge clk) region_wr = 3'(1 << m);
        @(negedge clk) region_wr = 3'b0;
        zeros = 0;
        repeat (8) begin @(negedge clk); if (pat_word != 0 || chip_sel != 0) zeros++; end
        chk("R5 ignored", 32'(zeros), 32'd0);
        cfg_op[2*m +: 2] = 2'b11;
      end

    // R11: rewrite one word with its select bit clear
    @(negedge clk) begin ram_we = 1'b1; ram_waddr = 6'h24; ram_wdata = wexp(36) & ~32'h10; end
    @(negedge clk) ram_we = 1'b0;
    cfg_start[12 +: 6] = 6'h24;
    @(negedge clk) region_wr = 3'b100;
    @(negedge clk) region_wr = 3'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 new word", pat_word, wexp(36) & ~32'h10);
    chk("R11 cs gated", 32'(chip_sel), 32'd0);
    @(negedge clk);
    chk("R11 next cs", 32'(chip_sel), 32'b100);
    repeat (4) @(negedge clk);
    @(negedge clk) begin ram_we = 1'b1; ram_waddr = 6'h24; ram_wdata = wexp(36); end
    @(negedge clk) ram_we = 1'b0;

    // R8: timeout pattern for each bank value
    for (int b = 0; b < 4; b++) begin
      @(negedge clk) begin bmon_timeout = 1'b1; bmon_bank = 2'(b); end
      @(negedge clk) bmon_timeout = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        chk("R8 word", pat_word, wexp(60 + k));
        chk("R8 cs", 32'(chip_sel), (b < 3) ? 32'(1 << b) : 32'd0);
        chk("R8 ack", 32'(xfer_ack), 32'd1);
        @(negedge clk);
      end
      chk("R8 end", pat_word, 32'd0);
    end

    // R10 and R9: requests during a running pattern wait, then go in priority order
    cfg_start = {6'h08, 6'h04, 6'h00};
    @(negedge clk) region_wr = 3'b001;
    @(negedge clk) begin region_wr = 3'b110; bmon_timeout = 1'b1; bmon_bank = 2'd2; end
    @(negedge clk) begin region_wr = 3'b000; bmon_timeout = 1'b0; end
    capture(40);
    exp_n = 0;
    add_pat(0, 3'b001, 1'b0);
    add_pat(60, 3'b100, 1'b1);
    add_pat(4, 3'b010, 1'b0);
    add_pat(8, 3'b100, 1'b0);
    compare_cap("R10 order");

    // R2: refresh spacing for several periods
    cfg_rfen = 3'b001;
    for (int p = 1; p <= 3; p++) begin
      refresh_period = 8'(p);
      wait_ref_start(n);
      wait_ref_start(n);
      wait_ref_start(n);
      chk("R2 interval", 32'(n), 32'(32 * p));
    end

    // R3 R4: refresh enables, one combination at a time
    refresh_period = 8'd1;
    for (int r = 0; r < 8; r++) begin
      cfg_rfen = 3'(r);
      repeat (80) @(negedge clk);
      if (r % 2 == 1) begin
        wait_ref_start(n);
        for (int k = 0; k < 4; k++) begin
          chk("R4 word", pat_word, wexp(48 + k));
          chk("R4 mask", 32'(chip_sel), 32'(r | 1));
          chk("R7 ref ack", 32'(xfer_ack), 32'd1);
          @(negedge clk);
        end
      end else begin
        zeros = 0;
        repeat (80) begin @(negedge clk); if (pat_word != 0) zeros++; end
        chk("R3 no refresh", 32'(zeros), 32'd0);
      end
    end

    // R9: timeout, refresh and two runs pending together while idle
    cfg_rfen = 3'b001;
    wait_ref_start(n);
    repeat (29) @(negedge clk);
    bmon_timeout = 1'b1; bmon_bank = 2'd1; region_wr = 3'b110;
    @(negedge clk) begin bmon_timeout = 1'b0; region_wr = 3'b000; end
    capture(26);
    exp_n = 0;
    add_pat(60, 3'b010, 1'b1);
    add_pat(48, 3'b001, 1'b1);
    add_pat(4, 3'b010, 1'b0);
    add_pat(8, 3'b100, 1'b0);
    compare_cap("R9 priority");

    // R2: period zero stops refresh
    refresh_period = 8'd0; cfg_rfen = 3'b111;
    repeat (80) @(negedge clk);
    zeros = 0;
    repeat (100) begin @(negedge clk); if (pat_word != 0) zeros++; end
    chk("R2 period zero", 32'(zeros), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule